// File: doc/BRIEF.md
# Four-Register Nonlinear Keystream Generator

This block turns a 64-bit secret key and a 22-bit frame counter into a serial keystream. Three data shift registers (19, 22 and 23 bits) are stepped under the control of a fourth 17-bit register. The fourth register steps on every active cycle, and three of its bits choose by majority which data registers move. Each output bit combines the top bit of each data register with three nonlinear majority terms, and it passes through a one-stage delay before it leaves the block.

A single `start_i` pulse while the block is idle latches the key and the frame number and runs a fixed schedule with one register step per clock:
- 64 cycles of key injection.
- 22 cycles of frame injection.
- 100 mixing steps.
- One priming cycle that fills the delay stage.
- 228 output cycles.

The first 114 output bits belong to one link direction and the next 114 to the other. A one-cycle `done_o` pulse closes the run. Packing the bits into bytes and XORing them onto a payload are left to the surrounding logic.

Top module: `kstream4_gen`

## Requirements
- R1: While and after synchronous reset, `busy_o`, `ks_valid_o`, `ks_dir_o`, `ks_bit_o` and `done_o` are 0.
- R2: `start_i` is accepted only while the block is idle. A start pulse during a run is ignored, and the stream that run produces is unchanged. `busy_o` is 1 from the cycle after an accepted start until the run ends.
- R3: An accepted start clears all four registers. Then, for each of 64 key bits taken from `key_i[0]` up to `key_i[63]` and then 22 frame bits taken from `frame_i[0]` up to `frame_i[21]`, every register steps once and the input bit is XORed into bit 0. Each step is a left shift with the XOR of the tap bits entering bit 0. The taps are (18,17,16,13), (21,20), (22,21,20,7) and, for the control register, (16,11).
- R4: During mixing and output, the control register steps every cycle. The first, second and third data registers step only when control bit 10, 3 or 7 respectively equals the majority of those three bits.
- R5: On the step that injects frame bit 21, bits 15, 16 and 18 of the three data registers and bit 10 of the control register are set to 1 after the shift and before the XOR. So an all-zero key and frame still yield a non-zero stream.
- R6: The raw output is the XOR of data bits a[18], b[21] and c[22] with three majority terms: maj(a[15], ~a[14], a[12]), maj(~b[16], b[13], b[9]) and maj(c[18], c[16], ~c[13]).
- R7: After 100 mixing steps, one cycle loads the raw value of the mixed state into a delay bit without stepping. Each output cycle then steps once, emits the delay bit and reloads the delay bit from the new state. The first emitted bit is therefore the raw value of the mixed state.
- R8: Counting the clock edge that accepts the start as edge 0, `ks_valid_o` is high after edges 188 through 415. That is exactly 228 consecutive valid bits.
- R9: `ks_dir_o` is 0 for output bits 0 to 113 and 1 for bits 114 to 227.
- R10: `done_o` is high for exactly one cycle, after edge 416, which is the cycle after the last valid bit. At the same point `busy_o` drops, and a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| key_i | input | 64 | Secret key; bit 0 is injected first |
| frame_i | input | 22 | Frame number; bit 0 is injected first |
| busy_o | output | 1 | A run is in progress |
| ks_bit_o | output | 1 | Keystream bit |
| ks_valid_o | output | 1 | `ks_bit_o` carries a new bit |
| ks_dir_o | output | 1 | 0 for the first 114 bits, 1 for the rest |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench compares full 228-bit streams against a bit-level model for several key and frame patterns:
- An all-zero key and frame, whose stream is non-zero only because of the forced bits.
- All ones.
- A single key bit at the lowest position and a single key bit at the highest position, which tell the key injection order apart.
- A single top frame bit, which separates the frame order from the forcing step.
- Mixed patterns, which exercise the majority stepping and the nonlinear output terms together.

One mixed pattern is repeated with a stray start pulse in the middle of key loading, which shows that the pulse is ignored. Runs follow one another immediately, which shows the return to idle. Each run also checks the exact cycles of the first valid bit, the last valid bit, the direction change and the done pulse.

// File: rtl/kgen_pkg.sv
package kgen_pkg;

  localparam int KEY_BITS   = 64;
  localparam int FRAME_BITS = 22;
  localparam int MIX_STEPS  = 100;
  localparam int HALF_BITS  = 114;

  localparam int A_W = 19;
  localparam int B_W = 22;
  localparam int C_W = 23;
  localparam int D_W = 17;

  localparam logic [A_W-1:0] A_TAPS = 19'h72000;
  localparam logic [B_W-1:0] B_TAPS = 22'h300000;
  localparam logic [C_W-1:0] C_TAPS = 23'h700080;
  localparam logic [D_W-1:0] D_TAPS = 17'h10800;

  localparam int A_FORCE = 15;
  localparam int B_FORCE = 16;
  localparam int C_FORCE = 18;
  localparam int D_FORCE = 10;

  // pick index 0 is the top bit, 1..3 feed a majority term
  localparam logic [31:0] A_PICK = {8'd12, 8'd14, 8'd15, 8'd18};
  localparam logic [3:0]  A_INV  = 4'b0100;
  localparam logic [31:0] B_PICK = {8'd9, 8'd13, 8'd16, 8'd21};
  localparam logic [3:0]  B_INV  = 4'b0010;
  localparam logic [31:0] C_PICK = {8'd13, 8'd16, 8'd18, 8'd22};
  localparam logic [3:0]  C_INV  = 4'b1000;
  // control gates for registers a, b, c at picks 0, 1, 2
  localparam logic [23:0] D_PICK = {8'd7, 8'd3, 8'd10};
  localparam logic [2:0]  D_INV  = 3'b000;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_KEY,
    PH_FRAME,
    PH_MIX,
    PH_PRIME,
    PH_OUT,
    PH_DONE
  } phase_t;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/kgen_lfsr.sv
module kgen_lfsr #(
  parameter int             W         = 19,
  parameter logic [W-1:0]   TAPS      = '1,
  parameter int             FORCE_POS = 0,
  parameter int             NPICK     = 4,
  parameter logic [8*NPICK-1:0] PICK_POS = '0,
  parameter logic [NPICK-1:0]   PICK_INV = '0,
  parameter bit             PICK_NEXT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             force_i,
  input  logic             inject_i,
  input  logic             in_bit_i,
  output logic [NPICK-1:0] pick_o
);

  logic [W-1:0] q;
  logic [W-1:0] shifted;
  logic [W-1:0] q_next;
  logic [W-1:0] src;

  always_comb begin
    shifted = {q[W-2:0], ^(q & TAPS)};
    if (force_i) shifted[FORCE_POS] = 1'b1;
    shifted[0] = shifted[0] ^ (inject_i & in_bit_i);
    q_next = step_i ? shifted : q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) q <= '0;
    else                q <= q_next;
  end

  generate
    if (PICK_NEXT) begin : g_src_next
      assign src = q_next;
    end else begin : g_src_now
      assign src = q;
    end
    for (genvar k = 0; k < NPICK; k++) begin : g_pick
      localparam int POS = int'(PICK_POS[8*k +: 8]);
      assign pick_o[k] = src[POS] ^ PICK_INV[k];
    end
  endgenerate

  // R4: a register that is not stepped keeps its contents
  p_hold_unstepped_r4: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !clear_i) |=> $stable(q));

  // R3: a start clears the register
  p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (q == '0));

endmodule

// File: rtl/kgen_gate.sv
module kgen_gate #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] gate_i,
  input  logic         active_i,
  input  logic         free_i,
  output logic [N-1:0] step_o
);
  import kgen_pkg::*;

  logic vote;
  assign vote = maj3(gate_i[0], gate_i[1], gate_i[2]);

  generate
    for (genvar k = 0; k < N; k++) begin : g_step
      assign step_o[k] = active_i & (free_i | (gate_i[k] == vote));
    end
  endgenerate

  // R4: under majority control at least two data registers move
  p_two_of_three_r4: assert property (@(posedge clk) disable iff (rst)
    (active_i && !free_i) |-> ($countones(step_o) >= 2));

  // R4: nothing moves outside an active phase
  p_idle_no_step_r4: assert property (@(posedge clk) disable iff (rst)
    !active_i |-> (step_o == '0));

endmodule

// File: rtl/kgen_combine.sv
module kgen_combine (
  input  logic [3:0] pa_i,
  input  logic [3:0] pb_i,
  input  logic [3:0] pc_i,
  output logic       raw_o
);
  import kgen_pkg::*;

  assign raw_o = pa_i[0] ^ pb_i[0] ^ pc_i[0]
               ^ maj3(pa_i[1], pa_i[2], pa_i[3])
               ^ maj3(pb_i[1], pb_i[2], pb_i[3])
               ^ maj3(pc_i[1], pc_i[2], pc_i[3]);

endmodule

// File: rtl/kstream4_gen.sv
module kstream4_gen #(
  parameter int KEY_W     = kgen_pkg::KEY_BITS,
  parameter int FRAME_W   = kgen_pkg::FRAME_BITS,
  parameter int MIX_N     = kgen_pkg::MIX_STEPS,
  parameter int HALF_N    = kgen_pkg::HALF_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               busy_o,
  output logic               ks_bit_o,
  output logic               ks_valid_o,
  output logic               ks_dir_o,
  output logic               done_o
);
  import kgen_pkg::*;

  localparam int STREAM_N = 2 * HALF_N;
  localparam int MAX_A    = (KEY_W > MIX_N) ? KEY_W : MIX_N;
  localparam int MAX_C    = (MAX_A > STREAM_N) ? MAX_A : STREAM_N;
  localparam int CNT_W    = $clog2(MAX_C) + 1;
  localparam int KIDX_W   = $clog2(KEY_W);
  localparam int FIDX_W   = $clog2(FRAME_W);

  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic [KEY_W-1:0]   key_q;
  logic [FRAME_W-1:0] frame_q;
  logic               delay_q;

  logic       clear, load_ph, ctrl_ph, active, force_last, in_bit;
  logic [2:0] gates, data_step;
  logic [3:0] pa, pb, pc;
  logic       raw;

  assign clear      = (phase == PH_IDLE) && start_i;
  assign load_ph    = (phase == PH_KEY) || (phase == PH_FRAME);
  assign ctrl_ph    = (phase == PH_MIX) || (phase == PH_OUT);
  assign active     = load_ph || ctrl_ph;
  assign force_last = (phase == PH_FRAME) && (cnt == CNT_W'(FRAME_W - 1));
  assign in_bit     = (phase == PH_KEY) ? key_q[cnt[KIDX_W-1:0]]
                                        : frame_q[cnt[FIDX_W-1:0]];
  assign busy_o     = (phase != PH_IDLE);

  kgen_gate #(.N(3)) u_gate (
    .clk(clk), .rst(rst), .gate_i(gates), .active_i(active),
    .free_i(load_ph), .step_o(data_step)
  );

  kgen_lfsr #(.W(D_W), .TAPS(D_TAPS), .FORCE_POS(D_FORCE), .NPICK(3),
              .PICK_POS(D_PICK), .PICK_INV(D_INV), .PICK_NEXT(1'b0)) u_ctl (
    .clk(clk), .rst(rst), .clear_i(clear), .step_i(active),
    .force_i(force_last), .inject_i(load_ph), .in_bit_i(in_bit), .pick_o(gates)
  );

  kgen_lfsr #(.W(A_W), .TAPS(A_TAPS), .FORCE_POS(A_FORCE), .NPICK(4),
              .PICK_POS(A_PICK), .PICK_INV(A_INV), .PICK_NEXT(1'b1)) u_ra (
    .clk(clk), .rst(rst), .clear_i(clear), .step_i(data_step[0]),
    .force_i(force_last), .inject_i(load_ph), .in_bit_i(in_bit), .pick_o(pa)
  );

  kgen_lfsr #(.W(B_W), .TAPS(B_TAPS), .FORCE_POS(B_FORCE), .NPICK(4),
              .PICK_POS(B_PICK), .PICK_INV(B_INV), .PICK_NEXT(1'b1)) u_rb (
    .clk(clk), .rst(rst), .clear_i(clear), .step_i(data_step[1]),
    .force_i(force_last), .inject_i(load_ph), .in_bit_i(in_bit), .pick_o(pb)
  );

  kgen_lfsr #(.W(C_W), .TAPS(C_TAPS), .FORCE_POS(C_FORCE), .NPICK(4),
              .PICK_POS(C_PICK), .PICK_INV(C_INV), .PICK_NEXT(1'b1)) u_rc (
    .clk(clk), .rst(rst), .clear_i(clear), .step_i(data_step[2]),
    .force_i(force_last), .inject_i(load_ph), .in_bit_i(in_bit), .pick_o(pc)
  );

  // raw value of the state after this cycle's step (no step during PRIME)
  kgen_combine u_comb (.pa_i(pa), .pb_i(pb), .pc_i(pc), .raw_o(raw));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      key_q      <= '0;
      frame_q    <= '0;
      delay_q    <= 1'b0;
      ks_bit_o   <= 1'b0;
      ks_valid_o <= 1'b0;
      ks_dir_o   <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      ks_valid_o <= 1'b0;
      done_o     <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start_i) begin
          key_q    <= key_i;
          frame_q  <= frame_i;
          delay_q  <= 1'b0;
          ks_bit_o <= 1'b0;
          ks_dir_o <= 1'b0;
          cnt      <= '0;
          phase    <= PH_KEY;
        end
        PH_KEY: begin
          cnt <= (cnt == CNT_W'(KEY_W - 1)) ? '0 : cnt + 1'b1;
          if (cnt == CNT_W'(KEY_W - 1)) phase <= PH_FRAME;
        end
        PH_FRAME: begin
          cnt <= force_last ? '0 : cnt + 1'b1;
          if (force_last) phase <= PH_MIX;
        end
        PH_MIX: begin
          cnt <= (cnt == CNT_W'(MIX_N - 1)) ? '0 : cnt + 1'b1;
          if (cnt == CNT_W'(MIX_N - 1)) phase <= PH_PRIME;
        end
        PH_PRIME: begin
          delay_q <= raw;
          cnt     <= '0;
          phase   <= PH_OUT;
        end
        PH_OUT: begin
          ks_bit_o   <= delay_q;
          ks_valid_o <= 1'b1;
          ks_dir_o   <= (cnt >= CNT_W'(HALF_N));
          delay_q    <= raw;
          cnt        <= cnt + 1'b1;
          if (cnt == CNT_W'(STREAM_N - 1)) phase <= PH_DONE;
        end
        PH_DONE: begin
          done_o <= 1'b1;
          phase  <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2: latched inputs do not change during a run
  p_inputs_held_r2: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> $stable(key_q) && $stable(frame_q));

  // R8: valid bits only come from the output phase
  p_valid_from_output_r8: assert property (@(posedge clk) disable iff (rst)
    ks_valid_o |-> ($past(phase) == PH_OUT));

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10: done directly follows the last bit of the second direction
  p_done_after_last_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(ks_valid_o && ks_dir_o));

  // R9: direction never falls back while bits are streaming
  p_dir_monotone_r9: assert property (@(posedge clk) disable iff (rst)
    (ks_valid_o && ks_dir_o) |=> (!ks_valid_o || ks_dir_o));

endmodule

// File: tb/test_kstream4_gen.sv
module test_kstream4_gen;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [63:0] key;
  logic [21:0] frame;
  logic        busy, ks_bit, ks_valid, ks_dir, done;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  kstream4_gen i_kstream4_gen (
    .clk(clk), .rst(rst), .start_i(start), .key_i(key), .frame_i(frame),
    .busy_o(busy), .ks_bit_o(ks_bit), .ks_valid_o(ks_valid),
    .ks_dir_o(ks_dir), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------- bit-level reference model ----------
  function automatic logic mj(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic logic raw_of(input logic [18:0] a, input logic [21:0] b,
                                  input logic [22:0] c);
    return a[18] ^ b[21] ^ c[22]
         ^ mj(a[15], ~a[14], a[12])
         ^ mj(~b[16], b[13], b[9])
         ^ mj(c[18], c[16], ~c[13]);
  endfunction

  function automatic void ref_stream(input logic [63:0] k, input logic [21:0] f,
                                     output logic [227:0] ks);
    logic [18:0] a = '0;
    logic [21:0] b = '0;
    logic [22:0] c = '0;
    logic [16:0] d = '0;
    logic        dl;
    logic        m;
    logic        bt;
    for (int i = 0; i < 86; i++) begin
      bt = (i < 64) ? k[i] : f[i-64];
      a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13]};
      b = {b[20:0], b[21] ^ b[20]};
      c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7]};
      d = {d[15:0], d[16] ^ d[11]};
      if (i == 85) begin
        a[15] = 1'b1; b[16] = 1'b1; c[18] = 1'b1; d[10] = 1'b1;
      end
      a[0] ^= bt; b[0] ^= bt; c[0] ^= bt; d[0] ^= bt;
    end
    for (int i = 0; i < 100 + 228; i++) begin
      if (i == 100) dl = raw_of(a, b, c);
      m = mj(d[10], d[3], d[7]);
      if (d[10] == m) a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13]};
      if (d[3]  == m) b = {b[20:0], b[21] ^ b[20]};
      if (d[7]  == m) c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7]};
      d = {d[15:0], d[16] ^ d[11]};
      if (i >= 100) begin
        ks[i-100] = dl;
        dl = raw_of(a, b, c);
      end
    end
  endfunction

  // ---------- one full run ----------
  task automatic run_vec(input logic [63:0] k, input logic [21:0] f,
                         input bit poke, input bit zero_case);
    logic [227:0] exp_ks;
    logic [227:0] got = '0;
    int nv = 0, first_k = -1, last_k = -1, done_k = -1, n_done = 0;
    int dir_bad = 0;
    bit busy_early = 1'b0, busy_end = 1'b1;
    ref_stream(k, f, exp_ks);
    @(negedge clk);
    key = k; frame = f; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int e = 1; e <= 420; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e == 1) busy_early = busy;
      if (e == 416) busy_end = busy;
      if (ks_valid) begin
        if (first_k < 0) first_k = e;
        last_k = e;
        if (nv < 228) begin
          got[nv] = ks_bit;
          if (ks_dir != (nv >= 114)) dir_bad++;
        end
        nv++;
      end
      if (done) begin
        n_done++;
        done_k = e;
      end
      if (poke && e == 50) begin
        start = 1'b1; key = ~k; frame = ~f;
      end
      if (poke && e == 51) start = 1'b0;
    end
    for (int i = 0; i < 228; i++)
      check(got[i] == exp_ks[i], "R3/R4/R6", $sformatf("stream bit %0d", i),
            got[i], exp_ks[i]);
    check(got[0] == exp_ks[0], "R7", "first emitted bit", got[0], exp_ks[0]);
    if (zero_case)
      check(got != '0, "R5", "zero inputs give nonzero stream", $countones(got), 1);
    if (poke)
      check(got == exp_ks, "R2", "stream after stray start", $countones(got),
            $countones(exp_ks));
    check(busy_early == 1'b1, "R2", "busy after start", busy_early, 1);
    check(nv == 228, "R8", "valid count", nv, 228);
    check(first_k == 188, "R8", "first valid edge", first_k, 188);
    check(last_k == 415, "R8", "last valid edge", last_k, 415);
    check(dir_bad == 0, "R9", "direction flag errors", dir_bad, 0);
    check(n_done == 1, "R10", "done pulses", n_done, 1);
    check(done_k == 416, "R10", "done edge", done_k, 416);
    check(busy_end == 1'b0, "R10", "busy at done", busy_end, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; key = '0; frame = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check({busy, ks_valid, ks_dir, ks_bit, done} == 5'b0, "R1", "outputs in reset",
          {busy, ks_valid, ks_dir, ks_bit, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({busy, ks_valid, ks_dir, ks_bit, done} == 5'b0, "R1", "outputs after reset",
          {busy, ks_valid, ks_dir, ks_bit, done}, 0);

    run_vec(64'h0, 22'h0, 1'b0, 1'b1);                        // R5
    run_vec('1, '1, 1'b0, 1'b0);
    run_vec(64'h1, 22'h0, 1'b0, 1'b0);                        // R3 first key bit
    run_vec(64'h8000_0000_0000_0000, 22'h0, 1'b0, 1'b0);      // R3 last key bit
    run_vec(64'h0, 22'h20_0000, 1'b0, 1'b0);                  // R3/R5 last frame bit
    run_vec(64'h0123_4567_89AB_CDEF, 22'h2A5F3, 1'b0, 1'b0);
    run_vec(64'h0123_4567_89AB_CDEF, 22'h2A5F3, 1'b1, 1'b0);  // R2 stray start
    run_vec(64'hF00D_CAFE_1357_9BDF, 22'h0155A, 1'b0, 1'b0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule